// File: doc/BRIEF.md
# Camera Capture Control and Interrupt Register Block

This block is the software-visible control and status front end of a camera capture engine. It decodes a 32-bit word-addressed register port and keeps the global control word, the capture enable, the frame geometry words, a general-purpose word and two status words. The capture datapath reads its configuration as plain outputs: capture enable, colour-bar test pattern select and serial-versus-parallel input select.

Two small protocols run inside it. The first is a software reset handshake. Software raises a request bit. The block reports ready once the datapath says it is idle. Software then sets a commit bit, and the block gives the datapath a one-cycle reset pulse. After that, ready, request and commit clear themselves.

The second protocol is interrupt collection. The datapath sends four one-cycle event pulses: frame start, frame end, last capture done and overflow. Each event sets a sticky source flag. Each event also sets a combined pending flag, but only if that source's disable bit is clear. The interrupt line follows the pending flag. Software clears any flag by writing a zero to its bit.

Top module: `cam_ctrl_regs`

## Requirements
- R1: After synchronous reset, every register reads 0, and irq, dp_reset, capture_en, test_pattern and serial_sel are low.
- R2: The words at byte offsets 0x00, 0x10, 0x14 and 0xFC store any 32-bit value written to them and return it on read. An offset that maps to no register reads 0, and writing it has no effect.
- R3: Bit 31 of the capture enable word (offset 0x08) drives capture_en from the cycle after the write. The other bits of that word read 0.
- R4: In the global control word (offset 0x04), bit 15 drives test_pattern and bit 3 drives serial_sel.
- R5: Global control bit 18 (reset ready) is read-only and writes to it are ignored. It rises one cycle after a cycle in which the request bit 19 is set and dp_idle is high. It stays low while dp_idle is low, and it falls when bit 19 is cleared.
- R6: While ready and commit (bit 17) are both set, dp_reset is high for exactly one cycle. Ready falls at the next edge. Bits 19 and 17 clear themselves one edge after that.
- R7: Each event pulse sets its sticky flag in the status word (offset 0x40), whatever the disable bits say. The flags are: bit 7 overflow, bit 6 last capture, bit 5 frame start, bit 4 frame end.
- R8: An event pulse sets the pending flag (status bit 0) only when its disable bit in global control is 0. The disable bits are: bit 8 last capture, bit 7 frame end, bit 6 frame start, bit 5 overflow.
- R9: irq is high exactly while the pending flag is set.
- R10: Writing 0 to a status flag bit clears it, and writing 1 leaves it unchanged. The second status word (offset 0x44) behaves the same way: bit 1 is set by last capture and bit 0 by frame end.
- R11: When an event pulse and a clearing write to the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ev_frame_start | input | 1 | Frame start pulse from the datapath |
| ev_frame_end | input | 1 | Frame end pulse from the datapath |
| ev_last_capture | input | 1 | Last capture done pulse from the datapath |
| ev_overflow | input | 1 | Overflow pulse from the datapath |
| dp_idle | input | 1 | Datapath reports it is idle |
| dp_reset | output | 1 | One-cycle reset pulse to the datapath |
| capture_en | output | 1 | Capture running |
| test_pattern | output | 1 | Colour-bar test pattern select |
| serial_sel | output | 1 | Serial input path select (0 = parallel) |
| irq | output | 1 | Combined camera interrupt |

## Verification
The interrupt path is first driven with every source disabled. This separates the sticky source flags, which must still latch, from the pending flag, which must stay clear. It is then driven with each source enabled on its own, which exposes any swap between a disable bit and its event. The reset handshake is run with dp_idle held low and then released, so that a ready flag tied to the request alone stands out. Same-cycle event and clear stimulus tells the event-wins rule apart from a clear-wins rule. A long pseudo-random mix of writes, idle changes and events is compared against the bench model on every clock.

// File: rtl/cam_regs_pkg.sv
package cam_regs_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_EV  = 4;
    localparam int PLAIN_N = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_GCTRL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAPEN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 8'h44;
    localparam logic [ADDR_W-1:0] PLAIN_OFS [PLAIN_N] = '{8'h00, 8'h10, 8'h14, 8'hFC};

    // global control bit positions
    localparam int BIT_RST_REQ  = 19;
    localparam int BIT_RST_RDY  = 18;
    localparam int BIT_RST_CMT  = 17;
    localparam int BIT_TPAT     = 15;
    localparam int BIT_SERIAL   = 3;
    localparam int BIT_DIS_LAST = 8;
    localparam int BIT_DIS_FEND = 7;
    localparam int BIT_DIS_FST  = 6;
    localparam int BIT_DIS_OVF  = 5;

    // capture enable and status positions
    localparam int BIT_CAPEN    = 31;
    localparam int STAT_SRC_LSB = 4;
    localparam int BIT_PEND     = 0;

    // event vector order (LSB first): frame end, frame start, last, overflow
    localparam int EV_FEND  = 0;
    localparam int EV_FST   = 1;
    localparam int EV_LAST  = 2;
    localparam int EV_OVF   = 3;

    typedef struct packed {
        logic ovf;
        logic last;
        logic fstart;
        logic fend;
    } cam_ev_t;

    // gather the per-source disable bits in event vector order
    function automatic logic [NUM_EV-1:0] ev_disables(input logic [REG_W-1:0] gc);
        logic [NUM_EV-1:0] d;
        d[EV_FEND] = gc[BIT_DIS_FEND];
        d[EV_FST]  = gc[BIT_DIS_FST];
        d[EV_LAST] = gc[BIT_DIS_LAST];
        d[EV_OVF]  = gc[BIT_DIS_OVF];
        return d;
    endfunction

endpackage

// File: rtl/cam_swrst_fsm.sv
module cam_swrst_fsm (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic commit,
    input  logic dp_idle,
    output logic ready,
    output logic dp_reset,
    output logic self_clr
);
    logic done_q;

    assign dp_reset = ready & commit;
    assign self_clr = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= dp_reset;
            if (dp_reset || !req)
                ready <= 1'b0;
            else if (dp_idle && !done_q)
                ready <= 1'b1;
        end
    end
endmodule

// File: rtl/cam_irq_collect.sv
module cam_irq_collect
    import cam_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev,
    input  logic [NUM_EV-1:0] dis,
    input  logic              st_wr,
    input  logic [NUM_EV-1:0] st_keep_src,
    input  logic              st_keep_pend,
    input  logic              st2_wr,
    input  logic [1:0]        st2_keep,
    output logic [NUM_EV-1:0] src,
    output logic              pend,
    output logic [1:0]        st2
);
    logic [1:0] st2_set;
    assign st2_set = {ev[EV_LAST], ev[EV_FEND]};

    for (genvar i = 0; i < NUM_EV; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                src[i] <= 1'b0;
            else
                src[i] <= (src[i] & ~(st_wr & ~st_keep_src[i])) | ev[i];
        end
    end

    for (genvar j = 0; j < 2; j++) begin : g_st2
        always_ff @(posedge clk) begin
            if (rst)
                st2[j] <= 1'b0;
            else
                st2[j] <= (st2[j] & ~(st2_wr & ~st2_keep[j])) | st2_set[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else
            pend <= (pend & ~(st_wr & ~st_keep_pend)) | (|(ev & ~dis));
    end
endmodule

// File: rtl/cam_ctrl_regs.sv
module cam_ctrl_regs
    import cam_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_frame_start,
    input  logic              ev_frame_end,
    input  logic              ev_last_capture,
    input  logic              ev_overflow,
    input  logic              dp_idle,
    output logic              dp_reset,
    output logic              capture_en,
    output logic              test_pattern,
    output logic              serial_sel,
    output logic              irq
);
    logic [REG_W-1:0]  plain_q [PLAIN_N];
    logic [REG_W-1:0]  gc_q;
    logic              cap_q;
    logic              rst_ready;
    logic              rst_req;
    logic              self_clr;
    logic [NUM_EV-1:0] ev_vec;
    logic [NUM_EV-1:0] dis_vec;
    logic [NUM_EV-1:0] src_q;
    logic              pend_q;
    logic [1:0]        st2_q;
    cam_ev_t           ev_s;

    logic wr_gc, wr_cap, wr_st, wr_st2;
    assign wr_gc  = reg_wr && (reg_addr == OFS_GCTRL);
    assign wr_cap = reg_wr && (reg_addr == OFS_CAPEN);
    assign wr_st  = reg_wr && (reg_addr == OFS_STAT);
    assign wr_st2 = reg_wr && (reg_addr == OFS_STAT2);

    assign ev_s    = '{ovf: ev_overflow, last: ev_last_capture,
                       fstart: ev_frame_start, fend: ev_frame_end};
    assign ev_vec  = ev_s;
    assign dis_vec = ev_disables(gc_q);
    assign rst_req = gc_q[BIT_RST_REQ];

    // plain storage words
    for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[g] <= '0;
            else if (reg_wr && (reg_addr == PLAIN_OFS[g]))
                plain_q[g] <= reg_wdata;
        end
    end

    // global control: ready bit is never stored, handshake bits self-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            gc_q <= '0;
        end else begin
            logic [REG_W-1:0] nxt;
            nxt = gc_q;
            if (wr_gc)
                nxt = reg_wdata;
            nxt[BIT_RST_RDY] = 1'b0;
            if (self_clr) begin
                nxt[BIT_RST_REQ] = 1'b0;
                nxt[BIT_RST_CMT] = 1'b0;
            end
            gc_q <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= 1'b0;
        else if (wr_cap)
            cap_q <= reg_wdata[BIT_CAPEN];
    end

    cam_swrst_fsm u_swrst (
        .clk      (clk),
        .rst      (rst),
        .req      (gc_q[BIT_RST_REQ]),
        .commit   (gc_q[BIT_RST_CMT]),
        .dp_idle  (dp_idle),
        .ready    (rst_ready),
        .dp_reset (dp_reset),
        .self_clr (self_clr)
    );

    cam_irq_collect u_irq (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev_vec),
        .dis          (dis_vec),
        .st_wr        (wr_st),
        .st_keep_src  (reg_wdata[STAT_SRC_LSB +: NUM_EV]),
        .st_keep_pend (reg_wdata[BIT_PEND]),
        .st2_wr       (wr_st2),
        .st2_keep     (reg_wdata[1:0]),
        .src          (src_q),
        .pend         (pend_q),
        .st2          (st2_q)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < PLAIN_N; k++)
            if (reg_addr == PLAIN_OFS[k])
                reg_rdata = plain_q[k];
        case (reg_addr)
            OFS_GCTRL: begin
                reg_rdata = gc_q;
                reg_rdata[BIT_RST_RDY] = rst_ready;
            end
            OFS_CAPEN: reg_rdata[BIT_CAPEN] = cap_q;
            OFS_STAT: begin
                reg_rdata[STAT_SRC_LSB +: NUM_EV] = src_q;
                reg_rdata[BIT_PEND] = pend_q;
            end
            OFS_STAT2: reg_rdata[1:0] = st2_q;
            default: ;
        endcase
    end

    assign capture_en   = cap_q;
    assign test_pattern = gc_q[BIT_TPAT];
    assign serial_sel   = gc_q[BIT_SERIAL];
    assign irq          = pend_q;
endmodule

// File: rtl/cam_ctrl_regs_chk.sv
module cam_ctrl_regs_chk
    import cam_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              dp_reset,
    input logic              dp_idle,
    input logic [NUM_EV-1:0] ev_vec,
    input logic [NUM_EV-1:0] dis_vec,
    input logic              rst_ready,
    input logic              rst_req
);
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        dp_reset |=> !dp_reset);

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
        dp_reset |=> !rst_ready);

    assert_ready_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_ready) |-> ($past(rst_req) && $past(dp_idle)));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(ev_vec & ~dis_vec)));

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (|(ev_vec & ~dis_vec)) |=> irq);
endmodule

bind cam_ctrl_regs cam_ctrl_regs_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .dp_reset  (dp_reset),
    .dp_idle   (dp_idle),
    .ev_vec    (ev_vec),
    .dis_vec   (dis_vec),
    .rst_ready (rst_ready),
    .rst_req   (rst_req)
);

// File: tb/test_cam_ctrl_regs.sv
module test_cam_ctrl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_frame_start = 1'b0, ev_frame_end = 1'b0;
    logic        ev_last_capture = 1'b0, ev_overflow = 1'b0;
    logic        dp_idle = 1'b0;
    logic        dp_reset, capture_en, test_pattern, serial_sel, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_ctrl_regs i_cam_ctrl_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_frame_start(ev_frame_start), .ev_frame_end(ev_frame_end),
        .ev_last_capture(ev_last_capture), .ev_overflow(ev_overflow),
        .dp_idle(dp_idle), .dp_reset(dp_reset), .capture_en(capture_en),
        .test_pattern(test_pattern), .serial_sel(serial_sel), .irq(irq)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done_flag = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [31:0] m_plain [int];
    logic [31:0] m_gc;
    bit          m_ready, m_done, m_cap, m_pend;
    bit   [3:0]  m_src;      // bit0 fend, bit1 fstart, bit2 last, bit3 ovf
    bit   [1:0]  m_s2;
    int          dis_pos [4] = '{7, 6, 8, 5};

    function automatic void model_reset();
        m_plain.delete();
        m_gc = '0; m_ready = 0; m_done = 0; m_cap = 0; m_pend = 0;
        m_src = '0; m_s2 = '0;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00 || a == 8'h10 || a == 8'h14 || a == 8'hFC)
            r = m_plain.exists(a) ? m_plain[a] : 32'h0;
        else if (a == 8'h04) begin
            r = m_gc; r[18] = m_ready;
        end else if (a == 8'h08)
            r[31] = m_cap;
        else if (a == 8'h40) begin
            r[7:4] = m_src; r[0] = m_pend;
        end else if (a == 8'h44)
            r[1:0] = m_s2;
        return r;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare, advance model, wait next negedge
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit [3:0] ev, input bit idle);
        bit exp_dpr;
        bit any_ev;
        reg_wr = wr; reg_addr = a; reg_wdata = d; dp_idle = idle;
        ev_frame_end = ev[0]; ev_frame_start = ev[1];
        ev_last_capture = ev[2]; ev_overflow = ev[3];
        #1;
        exp_dpr = m_gc[17] && m_ready;
        check("rdata",        reg_rdata,    model_read(a));
        check("dp_reset",     dp_reset,     exp_dpr);
        check("capture_en",   capture_en,   m_cap);
        check("test_pattern", test_pattern, m_gc[15]);
        check("serial_sel",   serial_sel,   m_gc[3]);
        check("irq",          irq,          m_pend);
        // model update from pre-edge state
        any_ev = 0;
        for (int i = 0; i < 4; i++)
            if (ev[i] && !m_gc[dis_pos[i]]) any_ev = 1;
        if (wr && a == 8'h40) begin
            if (!d[0]) m_pend = 0;
            for (int i = 0; i < 4; i++) if (!d[4+i]) m_src[i] = 0;
        end
        if (wr && a == 8'h44) begin
            if (!d[0]) m_s2[0] = 0;
            if (!d[1]) m_s2[1] = 0;
        end
        if (any_ev) m_pend = 1;
        m_src = m_src | ev;
        if (ev[0]) m_s2[0] = 1;
        if (ev[2]) m_s2[1] = 1;
        if (wr && (a == 8'h00 || a == 8'h10 || a == 8'h14 || a == 8'hFC)) m_plain[a] = d;
        if (wr && a == 8'h08) m_cap = d[31];
        begin
            bit req_now = m_gc[19];
            bit done_now = m_done;
            if (exp_dpr || !req_now) m_ready = 0;
            else if (idle && !done_now) m_ready = 1;
            m_done = exp_dpr;
            if (wr && a == 8'h04) m_gc = d;
            m_gc[18] = 0;
            if (done_now) begin m_gc[19] = 0; m_gc[17] = 0; end
        end
        @(negedge clk);
    endtask

    task automatic idle_n(input int n, input logic [7:0] a, input bit idle);
        for (int i = 0; i < n; i++) step(0, a, 32'h0, 4'h0, idle);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] addrs [9] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h40, 8'h44, 8'hFC, 8'h20};
        model_reset();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;

        // R1: reset values on every offset
        cur_req = "R1";
        for (int i = 0; i < 9; i++) step(0, addrs[i], 32'h0, 4'h0, 1);

        // R2: plain storage and unmapped offset
        cur_req = "R2";
        step(1, 8'h00, 32'hA5A5_1234, 4'h0, 1);
        step(1, 8'h10, 32'h0011_0022, 4'h0, 1);
        step(1, 8'h14, 32'hFFFF_0000, 4'h0, 1);
        step(1, 8'hFC, 32'h0000_0001, 4'h0, 1);
        step(1, 8'h20, 32'hDEAD_BEEF, 4'h0, 1);
        for (int i = 0; i < 9; i++) step(0, addrs[i], 32'h0, 4'h0, 1);

        // R3: capture enable bit 31 only
        cur_req = "R3";
        step(1, 8'h08, 32'hFFFF_FFFF, 4'h0, 1);
        idle_n(2, 8'h08, 1);
        step(1, 8'h08, 32'h0000_0000, 4'h0, 1);
        idle_n(1, 8'h08, 1);

        // R4: test pattern and serial select
        cur_req = "R4";
        step(1, 8'h04, 32'h0000_8000, 4'h0, 1);
        step(1, 8'h04, 32'h0000_0008, 4'h0, 1);
        step(1, 8'h04, 32'h0000_0000, 4'h0, 1);
        idle_n(1, 8'h04, 1);

        // R5: ready waits for idle, bit 18 write ignored
        cur_req = "R5";
        step(1, 8'h04, 32'h0004_0000, 4'h0, 0);
        idle_n(3, 8'h04, 0);
        step(1, 8'h04, 32'h0008_0000, 4'h0, 0);
        idle_n(3, 8'h04, 0);
        idle_n(3, 8'h04, 1);
        step(1, 8'h04, 32'h0000_0000, 4'h0, 1);
        idle_n(2, 8'h04, 1);

        // R6: full request/ready/commit sequence
        cur_req = "R6";
        step(1, 8'h04, 32'h0008_0000, 4'h0, 1);
        idle_n(2, 8'h04, 1);
        step(1, 8'h04, 32'h000A_0000, 4'h0, 1);
        idle_n(5, 8'h04, 1);
        step(1, 8'h04, 32'h000A_0000, 4'h0, 1);   // request and commit together
        idle_n(6, 8'h04, 1);

        // R7: all sources disabled, flags still latch, no pending
        cur_req = "R7";
        step(1, 8'h04, 32'h0000_01E0, 4'h0, 1);
        for (int i = 0; i < 4; i++) step(0, 8'h40, 32'h0, 4'(1 << i), 1);
        idle_n(2, 8'h40, 1);
        idle_n(1, 8'h44, 1);

        // R10: clear by writing zero, ones keep
        cur_req = "R10";
        step(1, 8'h40, 32'h0000_00A0, 4'h0, 1);
        step(1, 8'h40, 32'h0000_0000, 4'h0, 1);
        step(1, 8'h44, 32'h0000_0001, 4'h0, 1);
        step(1, 8'h44, 32'h0000_0000, 4'h0, 1);
        idle_n(1, 8'h44, 1);

        // R8 / R9: one source enabled at a time
        for (int i = 0; i < 4; i++) begin
            logic [31:0] gc = 32'h0000_01E0;
            cur_req = "R8";
            gc[dis_pos[i]] = 1'b0;
            step(1, 8'h04, gc, 4'h0, 1);
            for (int j = 0; j < 4; j++) step(0, 8'h40, 32'h0, 4'(1 << j), 1);
            cur_req = "R9";
            idle_n(2, 8'h40, 1);
            step(1, 8'h40, 32'hFFFF_FFFE, 4'h0, 1);
            idle_n(1, 8'h40, 1);
            step(1, 8'h40, 32'h0, 4'h0, 1);
        end

        // R11: event and clear in the same cycle
        cur_req = "R11";
        step(1, 8'h04, 32'h0000_0000, 4'h0, 1);
        step(0, 8'h40, 32'h0, 4'h2, 1);
        step(1, 8'h40, 32'h0000_0000, 4'h2, 1);
        idle_n(2, 8'h40, 1);
        step(1, 8'h44, 32'h0000_0000, 4'h5, 1);
        idle_n(2, 8'h44, 1);

        // mixed pseudo-random traffic (R5, R6, R8, R10 interplay)
        cur_req = "R10";
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 3000; n++) begin
            bit wr = ($urandom % 4) == 0;
            logic [7:0] a = addrs[$urandom % 9];
            logic [31:0] d = $urandom;
            bit [3:0] ev = 4'($urandom % 16) & 4'($urandom % 16);
            bit idle = ($urandom % 3) != 0;
            step(wr, a, d, ev, idle);
        end

        finish_run();
    end
endmodule